// File: doc/BRIEF.md
# Serial DAC Frame Sender

This block is the host end of a three-wire serial link to a four-channel current-output DAC. A write request arrives on a valid/ready handshake. It carries a 2-bit channel address, a data word and a commit flag. The block packs the address and data into one word and left-pads it with zero filler bits to a whole number of bytes. It sends the frame MSB first with chip select held low for the full frame, so a host that streams whole bytes sees one uninterrupted transfer.

The serial clock idles low. Data changes on its falling edge and the DAC samples it on the rising edge. After the last rising edge the block holds chip select low for a hold window and then raises it. If the commit flag was set, it then waits a setup window and drives the active-low load strobe for a minimum width, followed by a hold window. With the flag clear the strobe stays high. Several channels can therefore be staged and later updated together by one committing request.

Every timing window is a parameter counted in system clock cycles. The defaults suit a 200 MHz clock and the DAC's minimums: 25 ns clock high and low, 20 ns data setup, 25 ns chip-select hold, 5 ns load setup, 25 ns load width and 25 ns load hold.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset, cs_no=1, ldac_no=1, sclk_o=0 and req_ready_o=1.
- R2: Each frame is 24 rising serial clock edges long, MSB first. The first six bits are 0, the next two are the channel address (high bit first), and the last sixteen are the data word (MSB first).
- R3: Each accepted request produces exactly one chip-select low window, and all 24 rising clock edges of that frame fall inside it.
- R4: sclk_o is low whenever cs_no is high, and sdi_o does not change while sclk_o is high.
- R5: Each serial clock high phase and low phase lasts at least HALF_CYC cycles. The first rising edge comes at least CS_SETUP_CYC cycles after chip select falls.
- R6: Chip select rises at least CS_HOLD_CYC cycles after the last falling edge of the serial clock.
- R7: For a request with commit=1, exactly one ldac_no low pulse follows the frame. It starts at least LD_SETUP_CYC cycles after chip select rises, lasts at least LD_WIDTH_CYC cycles, and chip select stays high throughout it.
- R8: For a request with commit=0, ldac_no stays high until the next frame starts.
- R9: req_ready_o is low from the cycle after acceptance until chip select is high and any load pulse and its hold window are over. Chip select cannot fall again until LD_HOLD_CYC cycles after ldac_no rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Channel address |
| req_data_i | input | DATA_W | DAC code |
| req_commit_i | input | 1 | Pulse load strobe after this frame |
| sclk_o | output | 1 | Serial clock, idles low |
| sdi_o | output | 1 | Serial data, changes on falling edge |
| cs_no | output | 1 | Active-low chip select |
| ldac_no | output | 1 | Active-low load strobe |

## Verification
Two events can meet in the same cycle: the end of a load hold window and a new request that is already waiting. The bench provokes this by keeping req_valid_i high across consecutive committing requests, so the next acceptance lands in the first cycle the block returns to idle. The bench judges the result by measuring, at the ports, the gap between the ldac_no rise and the next chip-select fall. It also checks that the ldac_no pulses counted for each frame match that frame's commit flag, and that the data decoded from the frame is the request that was queued, not the one waiting behind it.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_CSHOLD, ST_LDSET, ST_LDLOW, ST_LDHOLD
  } tx_state_e;
endpackage

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dac_tx_shreg.sv
module dac_tx_shreg #(
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (load_i)   sh_q <= data_i;
    else if (shift_i)  sh_q <= {sh_q[WIDTH-2:0], 1'b0};
  end

  assign msb_o = sh_q[WIDTH-1];
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_tx_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 16,
  parameter int HALF_CYC     = 5,
  parameter int CS_SETUP_CYC = 4,
  parameter int CS_HOLD_CYC  = 5,
  parameter int LD_SETUP_CYC = 1,
  parameter int LD_WIDTH_CYC = 5,
  parameter int LD_HOLD_CYC  = 5,
  parameter int CNT_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              req_commit_i,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              cs_no,
  output logic              ldac_no
);
  localparam int RAW_W   = ADDR_W + DATA_W;
  localparam int NBYTES  = (RAW_W + 7) / 8;
  localparam int FRAME_W = NBYTES * 8;
  localparam int PAD_W   = FRAME_W - RAW_W;
  localparam int BIT_W   = $clog2(FRAME_W);

  tx_state_e        st_q, st_d;
  logic             tmr_ld, tmr_zero, sh_ld, sh_sh;
  logic [CNT_W-1:0] tmr_val;
  logic [BIT_W-1:0] bit_cnt_q;
  logic             commit_q, last_bit;
  logic             sclk_q, cs_n_q, ldac_n_q, ready_q;
  logic [FRAME_W-1:0] frame_d;

  // right-justified frame, zero filler in front
  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_d = {{PAD_W{1'b0}}, req_addr_i, req_data_i};
    end else begin : g_nopad
      assign frame_d = {req_addr_i, req_data_i};
    end
  endgenerate

  dac_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  dac_tx_shreg #(.WIDTH(FRAME_W)) u_shreg (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(sh_ld), .shift_i(sh_sh),
    .data_i(frame_d), .msb_o(sdi_o)
  );

  assign last_bit = (bit_cnt_q == BIT_W'(FRAME_W - 1));

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    sh_ld   = 1'b0;
    sh_sh   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid_i) begin
        st_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = CNT_W'(CS_SETUP_CYC - 1); sh_ld = 1'b1;
      end
      ST_SETUP: if (tmr_zero) begin
        st_d = ST_HIGH; tmr_ld = 1'b1; tmr_val = CNT_W'(HALF_CYC - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        tmr_ld = 1'b1;
        if (last_bit) begin
          st_d = ST_CSHOLD; tmr_val = CNT_W'(CS_HOLD_CYC - 1);
        end else begin
          st_d = ST_LOW; tmr_val = CNT_W'(HALF_CYC - 1); sh_sh = 1'b1;
        end
      end
      ST_LOW: if (tmr_zero) begin
        st_d = ST_HIGH; tmr_ld = 1'b1; tmr_val = CNT_W'(HALF_CYC - 1);
      end
      ST_CSHOLD: if (tmr_zero) begin
        if (commit_q) begin
          st_d = ST_LDSET; tmr_ld = 1'b1; tmr_val = CNT_W'(LD_SETUP_CYC - 1);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_LDSET: if (tmr_zero) begin
        st_d = ST_LDLOW; tmr_ld = 1'b1; tmr_val = CNT_W'(LD_WIDTH_CYC - 1);
      end
      ST_LDLOW: if (tmr_zero) begin
        st_d = ST_LDHOLD; tmr_ld = 1'b1; tmr_val = CNT_W'(LD_HOLD_CYC - 1);
      end
      ST_LDHOLD: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      commit_q  <= 1'b0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      ldac_n_q  <= 1'b1;
      ready_q   <= 1'b1;
    end else begin
      st_q <= st_d;
      if (sh_ld)      bit_cnt_q <= '0;
      else if (sh_sh) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (sh_ld) commit_q <= req_commit_i;
      sclk_q   <= (st_d == ST_HIGH);
      cs_n_q   <= (st_d == ST_IDLE) || (st_d == ST_LDSET) ||
                  (st_d == ST_LDLOW) || (st_d == ST_LDHOLD);
      ldac_n_q <= (st_d != ST_LDLOW);
      ready_q  <= (st_d == ST_IDLE);
    end
  end

  assign sclk_o      = sclk_q;
  assign cs_no       = cs_n_q;
  assign ldac_no     = ldac_n_q;
  assign req_ready_o = ready_q;

  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_sdi_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdi_o));
  p_cs_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> last_bit);
  p_ldac_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_no |-> cs_no);
  p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cs_no && ldac_no));
  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> (!req_ready_o && !cs_no));
  p_no_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CSHOLD && !commit_q) |=> ldac_no);
endmodule

// File: tb/dac_frame_tx_test.sv
module dac_frame_tx_test;
  localparam int HALF = 5, CSS = 4, CSH = 5, LDS = 1, LDW = 5, LDH = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_commit = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic req_ready, sclk, sdi, cs_n, ldac_n;

  int checks = 0, fails = 0;
  logic [23:0] exp_frame [0:127];
  logic        exp_commit [0:127];
  int wr = 0, rd = 0;

  always #2.5 clk = ~clk;

  dac_frame_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_commit_i(req_commit),
    .sclk_o(sclk), .sdi_o(sdi), .cs_no(cs_n), .ldac_no(ldac_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ldac = 1'b1, p_sdi = 1'b0;
  int lvl_cnt = 0, since_csf = 0, since_sclkf = 0, since_csr = 0, ld_low = 0, since_ldr = 0;
  int bits = 0, pulses = 0, frames = 0;
  bit had_pulse = 0, viol4 = 0, viol9 = 0, first_rise = 0;
  logic [23:0] shreg = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_n && sclk) viol4 = 1;
      if (sclk && p_sclk && sdi != p_sdi) viol4 = 1;
      if ((!cs_n || !ldac_n) && req_ready) viol9 = 1;
      // chip select fall
      if (p_cs && !cs_n) begin
        if (frames > 0) begin
          if (exp_commit[rd-1]) chk(pulses == 1, "R7 one load pulse", pulses, 1);
          else                  chk(pulses == 0, "R8 no load pulse", pulses, 0);
        end
        if (had_pulse) chk(since_ldr >= LDH, "R9 load hold before next frame", since_ldr, LDH);
        had_pulse = 0; pulses = 0; bits = 0; shreg = '0; since_csf = 0; first_rise = 1;
      end
      // serial clock edges
      if (!p_sclk && sclk) begin
        if (first_rise) chk(since_csf >= CSS, "R5 cs setup", since_csf, CSS);
        else            chk(lvl_cnt >= HALF, "R5 sclk low width", lvl_cnt, HALF);
        first_rise = 0;
        if (cs_n) viol4 = 1;
        shreg = {shreg[22:0], sdi};
        bits++;
      end
      if (p_sclk && !sclk) begin
        chk(lvl_cnt >= HALF, "R5 sclk high width", lvl_cnt, HALF);
        since_sclkf = 0;
      end
      // chip select rise
      if (!p_cs && cs_n) begin
        chk(bits == 24, "R3 clocks in cs window", bits, 24);
        chk(shreg == exp_frame[rd], "R2 frame content", int'(shreg), int'(exp_frame[rd]));
        chk(shreg[23:18] == 6'd0, "R2 filler zero", int'(shreg[23:18]), 0);
        chk(since_sclkf >= CSH, "R6 cs hold", since_sclkf, CSH);
        chk(!viol4, "R4 sclk idle and sdi stable", int'(viol4), 0);
        chk(!viol9, "R9 ready low while busy", int'(viol9), 0);
        viol4 = 0; viol9 = 0;
        rd++; frames++; since_csr = 0;
      end
      // load strobe
      if (p_ldac && !ldac_n) begin
        chk(since_csr >= LDS, "R7 load setup", since_csr, LDS);
        chk(cs_n == 1'b1, "R7 cs high during load", int'(cs_n), 1);
        pulses++; ld_low = 0;
      end
      if (!p_ldac && ldac_n) begin
        chk(ld_low >= LDW, "R7 load width", ld_low, LDW);
        had_pulse = 1; since_ldr = 0;
      end
      lvl_cnt = (p_sclk != sclk) ? 1 : lvl_cnt + 1;
      since_csf++; since_sclkf++; since_csr++; since_ldr++;
      if (!ldac_n) ld_low++;
      p_sclk = sclk; p_cs = cs_n; p_ldac = ldac_n; p_sdi = sdi;
    end
  end

  task automatic send(input logic [1:0] a, input logic [15:0] d, input bit c);
    req_addr = a; req_data = d; req_commit = c; req_valid = 1'b1;
    exp_frame[wr] = {6'd0, a, d}; exp_commit[wr] = c; wr++;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic gap(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int p, input int a);
    case (p)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'h0001;
      5: return 16'hA5C3 ^ 16'(a * 16'h1111);
      6: return 16'h0001 << (a * 4 + 1);
      default: return 16'h5AA5 + 16'(a);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs idle", int'(cs_n), 1);
    chk(ldac_n == 1'b1, "R1 ldac idle", int'(ldac_n), 1);
    chk(sclk == 1'b0, "R1 sclk idle", int'(sclk), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    // sweep, alternating gaps and back-to-back valid
    for (int a = 0; a < 4; a++) begin
      for (int p = 0; p < 8; p++) begin
        send(2'(a), pat(p, a), (p % 3) == 2);
        if (a[0]) gap(3);
      end
    end
    // staging three channels then one commit
    gap(2);
    send(2'd0, 16'h1234, 1'b0);
    send(2'd1, 16'h2345, 1'b0);
    send(2'd2, 16'h3456, 1'b0);
    send(2'd3, 16'h4567, 1'b1);
    // back-to-back commits: load hold meets waiting request
    send(2'd2, 16'hFEDC, 1'b1);
    send(2'd1, 16'h0F0F, 1'b1);
    gap(1);
    while (!req_ready) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(frames == wr, "R3 one window per request", frames, wr);
    if (exp_commit[rd-1]) chk(pulses == 1, "R7 final load pulse", pulses, 1);
    else                  chk(pulses == 0, "R8 final no pulse", pulses, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule